// File: doc/BRIEF.md
# Event Counter Bank

This block keeps a set of wide event counters for a processor core. It has 32 counter slots; slots 1 to 8 and 10 to 27 hold a counter, and slots 0, 9 and 28 to 31 are empty. Each cycle, an event vector with one bit per slot tells the bank which events fired. A counter advances by one when its event fires, its own count enable is set, the global run bit is set, and the mode the core is running in is allowed to count.

Software reaches the bank through one register port: an address, write data, a write strobe and combinational read data. Each counter is seen as two 32-bit words. A counter can be preset to the two's complement of a sampling period, so that it wraps after that many events. When a counter wraps, it sets its bit in a shared overflow status register. A single interrupt line is asserted while any status bit whose interrupt enable is set is high. Software clears a status bit by writing 0 to it. Because the two words of a counter are read separately, software reads high, low, high again and retries if the two high values differ.

Top module: `evt_counter_bank`

## Requirements
- R1: Counter k has its low word at address 2k and its high word at address 2k+1. The high word holds counter bits [CNT_W-1:32], zero-extended to 32 bits.
- R2: A counter advances by exactly one on a clock edge only when all of the following are set: its event bit, its count-enable bit, control bit 0 (run), and control bit 2 when priv_user is 0, or control bit 3 when priv_user is 1.
- R3: Writing 0x2 to the control register (address 0x40) stops all counting, and the control register reads back 0x2.
- R4: A control write with bits 31, 30 and 1 all set clears every counter and the whole overflow status at that edge. The count-enable and interrupt-enable registers keep their values, and the control register keeps bits [3:0] of the written word.
- R5: A write to a low or a high word changes only that half of the counter. If an event for that counter arrives in the same cycle, the written value wins and the event is dropped.
- R6: When a counter steps from all ones to zero, its bit in the overflow status register (address 0x43) is set at that same edge, and the counter goes on counting from zero.
- R7: A write to the overflow status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit.
- R8: irq is high exactly while some bit is set in both the overflow status and the interrupt-enable register (address 0x42).
- R9: Empty slots (0, 9, 28 to 31) read zero at both word addresses and ignore writes. Their bits in the count-enable (address 0x41), interrupt-enable and overflow status registers always read zero.
- R10: After reset, all counters, the control register, all enable registers and the overflow status are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Register address for both reads and writes |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Read data for addr |
| evt | input | 32 | Event pulses, one bit per slot |
| priv_user | input | 1 | 1 when the core runs in user mode, 0 in supervisor mode |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The hardest case to reach from the ports is a counter wrap. A 48-bit counter never gets there by counting alone, so the bench first presets both words to all ones with two separate writes and then sends a single event. It also drives an event and a low-word write to the same counter in one cycle, to show that the written value wins. Both overflows and the reset command are placed so that the status bit and irq can be watched being set and then cleared.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
    localparam int unsigned NUM_IDX = 32;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned IDX_W   = $clog2(NUM_IDX);
    localparam int unsigned ADDR_W  = IDX_W + 2;
    localparam int unsigned CTRL_W  = 4;

    // control space sits above the counter words
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(2 * NUM_IDX);
    localparam logic [ADDR_W-1:0] ADDR_CNT_EN = ADDR_W'(2 * NUM_IDX + 1);
    localparam logic [ADDR_W-1:0] ADDR_INT_EN = ADDR_W'(2 * NUM_IDX + 2);
    localparam logic [ADDR_W-1:0] ADDR_OVF    = ADDR_W'(2 * NUM_IDX + 3);

    // control bit positions
    localparam int unsigned CB_RUN   = 0;
    localparam int unsigned CB_SUPER = 2;
    localparam int unsigned CB_USER  = 3;

    function automatic logic slot_used(int unsigned k);
        return (k >= 1 && k <= 8) || (k >= 10 && k <= 27);
    endfunction

    function automatic logic [NUM_IDX-1:0] used_mask();
        logic [NUM_IDX-1:0] m;
        for (int unsigned k = 0; k < NUM_IDX; k++) m[k] = slot_used(k);
        return m;
    endfunction
endpackage

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
module ecb_counter #(
    parameter int unsigned CNT_W = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [ecb_pkg::WORD_W-1:0] wdata,
    input  logic                      inc,
    output logic [CNT_W-1:0]          count,
    output logic                      wrap
);
    import ecb_pkg::*;
    localparam int unsigned HI_W = CNT_W - WORD_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cnt[WORD_W-1:0]     = wdata;
            if (wr_hi) st_d.cnt[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi && !clear) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi && !clear) |=> $stable(count));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    assert_lo_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !clear) |=> (count[CNT_W-1:WORD_W] == $past(count[CNT_W-1:WORD_W])));
endmodule

// File: rtl/ecb_regs.sv
`timescale 1ns/1ps
module ecb_regs (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        wr_ctrl,
    input  logic                        wr_cnt_en,
    input  logic                        wr_int_en,
    input  logic                        wr_ovf,
    input  logic [ecb_pkg::WORD_W-1:0]  wdata,
    input  logic [ecb_pkg::NUM_IDX-1:0] evt,
    input  logic                        priv_user,
    input  logic [ecb_pkg::NUM_IDX-1:0] wrap_vec,
    output logic [ecb_pkg::NUM_IDX-1:0] inc_vec,
    output logic [ecb_pkg::CTRL_W-1:0]  ctrl,
    output logic [ecb_pkg::NUM_IDX-1:0] cnt_en,
    output logic [ecb_pkg::NUM_IDX-1:0] int_en,
    output logic [ecb_pkg::NUM_IDX-1:0] ovf,
    output logic                        irq
);
    import ecb_pkg::*;
    localparam logic [NUM_IDX-1:0] USED = used_mask();

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [NUM_IDX-1:0] cnt_en;
        logic [NUM_IDX-1:0] int_en;
        logic [NUM_IDX-1:0] ovf;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       mode_ok;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)   st_d.ctrl   = wdata[CTRL_W-1:0];
        if (wr_cnt_en) st_d.cnt_en = wdata & USED;
        if (wr_int_en) st_d.int_en = wdata & USED;
        if (clear)       st_d.ovf = '0;
        else if (wr_ovf) st_d.ovf = (st_q.ovf & wdata) | (wrap_vec & USED);
        else             st_d.ovf = st_q.ovf | (wrap_vec & USED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mode_ok = st_q.ctrl[CB_RUN] &&
                  (priv_user ? st_q.ctrl[CB_USER] : st_q.ctrl[CB_SUPER]);
        inc_vec = evt & st_q.cnt_en & {NUM_IDX{mode_ok}};
    end

    assign ctrl   = st_q.ctrl;
    assign cnt_en = st_q.cnt_en;
    assign int_en = st_q.int_en;
    assign ovf    = st_q.ovf;
    assign irq    = |(st_q.ovf & st_q.int_en);

    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_vec && !clear) |=> ((ovf & $past(wrap_vec)) == $past(wrap_vec)));

    assert_ovf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ovf == '0));

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_vec == '0) |=> ((ovf & ~$past(ovf)) == '0));

    assert_enables_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !wr_cnt_en && !wr_int_en) |=> ($stable(cnt_en) && $stable(int_en)));
endmodule

// File: rtl/evt_counter_bank.sv
`timescale 1ns/1ps
module evt_counter_bank #(
    parameter int unsigned CNT_W = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  addr,
    input  logic [31:0] wdata,
    input  logic        we,
    output logic [31:0] rdata,
    input  logic [31:0] evt,
    input  logic        priv_user,
    output logic        irq
);
    import ecb_pkg::*;

    logic [CNT_W-1:0]   cnt_arr [NUM_IDX];
    logic [NUM_IDX-1:0] wrap_vec, inc_vec, cnt_en, int_en, ovf;
    logic [CTRL_W-1:0]  ctrl;
    logic               wr_ctrl, reset_cmd;
    logic [IDX_W-1:0]   rd_idx;

    assign wr_ctrl   = we && (addr == ADDR_CTRL);
    assign reset_cmd = wr_ctrl && wdata[31] && wdata[30] && wdata[1];
    assign rd_idx    = addr[IDX_W:1];

    ecb_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (reset_cmd),
        .wr_ctrl   (wr_ctrl),
        .wr_cnt_en (we && (addr == ADDR_CNT_EN)),
        .wr_int_en (we && (addr == ADDR_INT_EN)),
        .wr_ovf    (we && (addr == ADDR_OVF)),
        .wdata     (wdata),
        .evt       (evt),
        .priv_user (priv_user),
        .wrap_vec  (wrap_vec),
        .inc_vec   (inc_vec),
        .ctrl      (ctrl),
        .cnt_en    (cnt_en),
        .int_en    (int_en),
        .ovf       (ovf),
        .irq       (irq)
    );

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_slot
        if (slot_used(k)) begin : g_cnt
            ecb_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (reset_cmd),
                .wr_lo (we && (addr == ADDR_W'(2 * k))),
                .wr_hi (we && (addr == ADDR_W'(2 * k + 1))),
                .wdata (wdata),
                .inc   (inc_vec[k]),
                .count (cnt_arr[k]),
                .wrap  (wrap_vec[k])
            );
        end else begin : g_empty
            assign cnt_arr[k]  = '0;
            assign wrap_vec[k] = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr[ADDR_W-1]) begin
            if (addr[0]) rdata = WORD_W'(cnt_arr[rd_idx] >> WORD_W);
            else         rdata = cnt_arr[rd_idx][WORD_W-1:0];
        end else begin
            case (addr)
                ADDR_CTRL:   rdata = WORD_W'(ctrl);
                ADDR_CNT_EN: rdata = cnt_en;
                ADDR_INT_EN: rdata = int_en;
                ADDR_OVF:    rdata = ovf;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: tb/evt_counter_bank_tb.sv
`timescale 1ns/1ps
module evt_counter_bank_tb;
    localparam logic [6:0] A_CTRL = 7'h40, A_CEN = 7'h41, A_IEN = 7'h42, A_OVF = 7'h43;

    logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, priv_user = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0, evt = '0, rdata;
    logic        irq;

    evt_counter_bank u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .we(we), .rdata(rdata), .evt(evt), .priv_user(priv_user), .irq(irq));

    always #4 clk = ~clk;

    typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
    item_t sb[$];
    int checks = 0, errors = 0;

    // slots with counters: 1..8 and 10..27 (R9)
    function automatic logic [31:0] used();
        logic [31:0] m = '0;
        for (int k = 1; k <= 27; k++) if (k != 9) m[k] = 1'b1;
        return m;
    endfunction

    initial begin : monitor
        item_t it;
        forever begin
            wait (sb.size() != 0);
            #2;
            it = sb.pop_front();
            checks++;
            if (it.is_irq) begin
                if (irq !== it.exp[0]) begin
                    errors++;
                    $display("FAIL %s irq actual %0b expected %0b", it.tag, irq, it.exp[0]);
                end
            end else if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s addr %h actual %h expected %h", it.tag, addr, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic expect_rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk); addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic expect_irq(input logic v, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'b0, v}; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic pulse(input logic [31:0] m, input int n);
        @(negedge clk); evt = m;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    initial begin : watchdog
        #1_600_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        expect_rd(A_CTRL, 32'h0, "R10");
        expect_rd(7'd2, 32'h0, "R10");
        expect_rd(A_OVF, 32'h0, "R10");
        expect_irq(1'b0, "R10");
        // R9 enable bits of empty slots read zero
        wr(A_CEN, 32'hFFFF_FFFF);
        expect_rd(A_CEN, used(), "R9");
        // R2 supervisor counting
        wr(A_CTRL, 32'h5); priv_user = 1'b0;
        pulse(32'h6, 5);
        expect_rd(7'd2, 32'd5, "R2");
        expect_rd(7'd4, 32'd5, "R2");
        // R2 user mode not enabled
        priv_user = 1'b1;
        pulse(32'h6, 3);
        expect_rd(7'd2, 32'd5, "R2");
        wr(A_CTRL, 32'hD);
        pulse(32'h6, 3);
        expect_rd(7'd2, 32'd8, "R2");
        expect_rd(7'd4, 32'd8, "R2");
        // R2 per-counter enable
        wr(A_CEN, used() & ~32'h4);
        pulse(32'h6, 2);
        expect_rd(7'd2, 32'd10, "R2");
        expect_rd(7'd4, 32'd8, "R2");
        // R3 stop command
        wr(A_CTRL, 32'h2);
        pulse(32'h6, 4);
        expect_rd(7'd2, 32'd10, "R3");
        expect_rd(A_CTRL, 32'h2, "R3");
        // R5 / R1 word writes on counter 5
        wr(7'd10, 32'hFFFF_FFFF);
        wr(7'd11, 32'h0001_2345);
        expect_rd(7'd10, 32'hFFFF_FFFF, "R5");
        expect_rd(7'd11, 32'h0000_2345, "R1");
        // R5 write beats event in the same cycle
        wr(A_CTRL, 32'hD);
        @(negedge clk); addr = 7'd10; wdata = 32'd7; we = 1'b1; evt = 32'h20;
        @(negedge clk); we = 1'b0; evt = '0;
        expect_rd(7'd10, 32'd7, "R5");
        expect_rd(7'd11, 32'h0000_2345, "R5");
        // R6 / R8 wrap
        wr(7'd10, 32'hFFFF_FFFF);
        wr(7'd11, 32'h0000_FFFF);
        wr(A_IEN, 32'h20);
        expect_irq(1'b0, "R8");
        pulse(32'h20, 1);
        expect_rd(7'd10, 32'h0, "R6");
        expect_rd(7'd11, 32'h0, "R6");
        expect_rd(A_OVF, 32'h20, "R6");
        expect_irq(1'b1, "R8");
        pulse(32'h20, 1);
        expect_rd(7'd10, 32'd1, "R6");
        wr(A_IEN, 32'h0);
        expect_irq(1'b0, "R8");
        wr(A_IEN, 32'h20);
        expect_irq(1'b1, "R8");
        // R7 status write semantics
        wr(A_OVF, 32'hFFFF_FFFF);
        expect_rd(A_OVF, 32'h20, "R7");
        wr(A_OVF, ~32'h20);
        expect_rd(A_OVF, 32'h0, "R7");
        expect_irq(1'b0, "R8");
        // R9 empty slots
        wr(7'd18, 32'h55);
        expect_rd(7'd18, 32'h0, "R9");
        wr(7'd19, 32'h66);
        expect_rd(7'd19, 32'h0, "R9");
        wr(7'd0, 32'hAA);
        expect_rd(7'd0, 32'h0, "R9");
        wr(A_IEN, 32'hFFFF_FFFF);
        expect_rd(A_IEN, used(), "R9");
        pulse(32'hF000_0201, 3);
        expect_rd(A_OVF, 32'h0, "R9");
        expect_irq(1'b0, "R9");
        // R4 reset command after a wrap on counter 27
        wr(7'd54, 32'hFFFF_FFFF);
        wr(7'd55, 32'h0000_FFFF);
        pulse(32'h0800_0000, 1);
        expect_rd(A_OVF, 32'h0800_0000, "R6");
        expect_rd(7'd55, 32'h0, "R1");
        expect_irq(1'b1, "R8");
        wr(A_CTRL, 32'hC000_0002);
        expect_rd(7'd2, 32'h0, "R4");
        expect_rd(7'd10, 32'h0, "R4");
        expect_rd(A_OVF, 32'h0, "R4");
        expect_rd(A_CTRL, 32'h2, "R4");
        expect_rd(A_IEN, used(), "R4");
        expect_irq(1'b0, "R4");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule